// File: doc/BRIEF.md
# Serial Channel Event Status Register

This block holds the sticky event flags of one serial channel. The channel runs in one of three framing modes: start/stop asynchronous, character-synchronous, or bit-oriented synchronous. Single-cycle pulses from the transmitter, the receiver and the clock-recovery logic each set their own status bit. Changes on the two modem control inputs, clear-to-send and carrier detect, are found by an internal edge detector and set their own bits. One bit reports the transmitter-idle level. The channel mode selects what each bit position means. Positions that the active mode does not define read as zero and ignore their event inputs.

Five kinds of clear act on different subsets of bits. A host write of one clears a bit. The transmitter reset command, the receiver reset command and a write into the transmit buffer each clear their own subset. A channel reset or the stop condition clears every bit. An interrupt request is raised when any readable status bit is set and its mask bit is enabled. The host reads the register through a combinational read port.

Top module: `chan_evt_status`

## Requirements
- R1: After a synchronous reset, every status bit reads 0 and `irq` is 0.
- R2: The mode input is encoded as 0 = asynchronous, 1 = character-synchronous and 2 = bit-synchronous. An event pulse sets its bit on the next clock edge, and the bit stays set until a clear acts on it. The event bits are: asynchronous mode, bit 2 = break start and bit 1 = break end; character-synchronous mode, bit 7 = underrun, bit 2 = clock loss and bit 1 = sync pattern; bit-synchronous mode, bit 7 = underrun, bit 2 = abort, bit 1 = idle start and bit 0 = flag.
- R3: A register write (`reg_sel` and `reg_wr` both high) clears each of bits 7, 4, 3, 2, 1 and 0 whose write-data bit is 1. A write-data bit of 0 leaves its status bit unchanged, and the write has no effect on bit 6. While `reg_sel` is low, `reg_rdata` is 0.
- R4: `tx_rst_cmd` clears bits 7, 6 and 3.
- R5: `rx_rst_cmd` clears bits 4, 2, 1 and 0.
- R6: `chan_rst_cmd` or `stop_mode` clears all bits.
- R7: Bit 6 takes the `tx_idle` level on each clock edge. It takes 0 instead when `txbuf_wr`, `tx_rst_cmd`, `chan_rst_cmd` or `stop_mode` is high on that edge.
- R8: Bit 4 is set by any rising or falling transition of `cts_lvl` between two edges. Bit 3 is set in the same way by `dcd_lvl`.
- R9: Bit 5 always reads 0. A bit the current mode does not define reads 0, and its event input is ignored. Mode 3 defines only bits 6, 4 and 3.
- R10: If an event sets a latched bit in the same cycle that a clear acts on it, the bit ends up set.
- R11: `irq` is high exactly when some readable status bit is 1 and its `irq_mask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Channel framing mode |
| reg_sel | input | 1 | Register selected by the host |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data (write one to clear) |
| reg_rdata | output | 8 | Status read data |
| irq_mask | input | 8 | Per-bit interrupt enable |
| irq | output | 1 | Interrupt request |
| tx_rst_cmd | input | 1 | Transmitter reset command pulse |
| rx_rst_cmd | input | 1 | Receiver reset command pulse |
| txbuf_wr | input | 1 | Write into the transmit buffer |
| chan_rst_cmd | input | 1 | Channel reset command pulse |
| stop_mode | input | 1 | System stop condition |
| tx_idle | input | 1 | Transmitter idle level |
| cts_lvl | input | 1 | Synchronized clear-to-send level |
| dcd_lvl | input | 1 | Synchronized carrier-detect level |
| ev_underrun | input | 1 | Transmit underrun pulse |
| ev_brk_start | input | 1 | Break start pulse |
| ev_brk_end | input | 1 | Break end pulse |
| ev_clk_miss | input | 1 | Clock loss pulse |
| ev_syn_hit | input | 1 | Sync pattern pulse |
| ev_flag | input | 1 | Flag detected pulse |
| ev_abort | input | 1 | Abort start pulse |
| ev_idle_start | input | 1 | Idle sequence start pulse |

## Verification
Every event input is pulsed once in each of the three modes. This shows whether the mode routes each pulse to the right position or blocks it. Writes of one are then compared with writes of zero, and each reset command is issued while all bits are set, which shows the clear subsets apart. A pulse that lands in the same cycle as each kind of clear tests set-over-clear priority. A long stretch of random pulses, levels, masks, writes and mode changes is compared cycle by cycle against a behavioural model. It covers mode changes while stale bits are stored, and modem-line toggles on both edges.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_BYTE  = 2'd1,
        MODE_BIT   = 2'd2,
        MODE_NONE  = 2'd3
    } chan_mode_e;

    localparam int STAT_W   = 8;
    localparam int B_UNDR   = 7;
    localparam int B_TXIDLE = 6;
    localparam int B_CTS    = 4;
    localparam int B_DCD    = 3;
    localparam int B_EV2    = 2;
    localparam int B_EV1    = 1;
    localparam int B_EV0    = 0;

    localparam logic [STAT_W-1:0] HOST_CLR_MASK = 8'b1001_1111;
    localparam logic [STAT_W-1:0] TXRST_MASK    = 8'b1100_1000;
    localparam logic [STAT_W-1:0] RXRST_MASK    = 8'b0001_0111;
    localparam logic [STAT_W-1:0] COMMON_MASK   = 8'b0101_1000;

    typedef struct packed {
        logic underrun;
        logic brk_start;
        logic brk_end;
        logic clk_miss;
        logic syn_hit;
        logic flag;
        logic abort;
        logic idle_start;
    } line_evt_t;

    typedef struct packed {
        logic              host_wr;
        logic [STAT_W-1:0] host_data;
        logic              tx_rst;
        logic              rx_rst;
        logic              txbuf_wr;
        logic              chan_clr;
    } clr_req_t;

    function automatic logic [STAT_W-1:0] valid_mask(chan_mode_e m);
        logic [STAT_W-1:0] v;
        v = COMMON_MASK;
        case (m)
            MODE_ASYNC: v = v | (8'b1 << B_EV2) | (8'b1 << B_EV1);
            MODE_BYTE:  v = v | (8'b1 << B_UNDR) | (8'b1 << B_EV2) | (8'b1 << B_EV1);
            MODE_BIT:   v = v | (8'b1 << B_UNDR) | (8'b1 << B_EV2) | (8'b1 << B_EV1)
                              | (8'b1 << B_EV0);
            default:    v = COMMON_MASK;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/line_change_det.sv
module line_change_det #(
    parameter int NLINES = 2
) (
    input  logic              clk,
    input  logic [NLINES-1:0] lvl,
    output logic [NLINES-1:0] chg
);
    logic [NLINES-1:0] prev;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            prev[i] <= lvl[i];
        end
        assign chg[i] = lvl[i] ^ prev[i];
    end
endmodule

// File: rtl/evt_router.sv
module evt_router
    import chan_evt_pkg::*;
(
    input  chan_mode_e        mode,
    input  line_evt_t         evt,
    input  logic [1:0]        line_chg,
    output logic [STAT_W-1:0] set_vec
);
    logic [STAT_W-1:0] raw;

    always_comb begin
        raw = '0;
        raw[B_CTS] = line_chg[0];
        raw[B_DCD] = line_chg[1];
        case (mode)
            MODE_ASYNC: begin
                raw[B_EV2] = evt.brk_start;
                raw[B_EV1] = evt.brk_end;
            end
            MODE_BYTE: begin
                raw[B_UNDR] = evt.underrun;
                raw[B_EV2]  = evt.clk_miss;
                raw[B_EV1]  = evt.syn_hit;
            end
            MODE_BIT: begin
                raw[B_UNDR] = evt.underrun;
                raw[B_EV2]  = evt.abort;
                raw[B_EV1]  = evt.idle_start;
                raw[B_EV0]  = evt.flag;
            end
            default: ;
        endcase
        set_vec = raw & valid_mask(mode);
    end
endmodule

// File: rtl/clr_router.sv
module clr_router
    import chan_evt_pkg::*;
(
    input  clr_req_t          req,
    output logic [STAT_W-1:0] clr_vec
);
    always_comb begin
        clr_vec = '0;
        if (req.host_wr)  clr_vec = clr_vec | (req.host_data & HOST_CLR_MASK);
        if (req.tx_rst)   clr_vec = clr_vec | TXRST_MASK;
        if (req.rx_rst)   clr_vec = clr_vec | RXRST_MASK;
        if (req.txbuf_wr) clr_vec[B_TXIDLE] = 1'b1;
        if (req.chan_clr) clr_vec = '1;
    end
endmodule

// File: rtl/chan_evt_status.sv
module chan_evt_status
    import chan_evt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic [7:0] irq_mask,
    output logic       irq,
    input  logic       tx_rst_cmd,
    input  logic       rx_rst_cmd,
    input  logic       txbuf_wr,
    input  logic       chan_rst_cmd,
    input  logic       stop_mode,
    input  logic       tx_idle,
    input  logic       cts_lvl,
    input  logic       dcd_lvl,
    input  logic       ev_underrun,
    input  logic       ev_brk_start,
    input  logic       ev_brk_end,
    input  logic       ev_clk_miss,
    input  logic       ev_syn_hit,
    input  logic       ev_flag,
    input  logic       ev_abort,
    input  logic       ev_idle_start
);
    chan_mode_e        cur_mode;
    logic [STAT_W-1:0] vmask, set_vec, clr_vec, stat, nxt;
    logic [1:0]        line_chg;
    line_evt_t         evt;
    clr_req_t          creq;
    logic              host_wr;

    assign cur_mode = chan_mode_e'(mode);
    assign vmask    = valid_mask(cur_mode);
    assign host_wr  = reg_sel & reg_wr;

    assign evt = '{underrun: ev_underrun, brk_start: ev_brk_start, brk_end: ev_brk_end,
                   clk_miss: ev_clk_miss, syn_hit: ev_syn_hit, flag: ev_flag,
                   abort: ev_abort, idle_start: ev_idle_start};

    assign creq = '{host_wr: host_wr, host_data: reg_wdata, tx_rst: tx_rst_cmd,
                    rx_rst: rx_rst_cmd, txbuf_wr: txbuf_wr,
                    chan_clr: chan_rst_cmd | stop_mode};

    line_change_det #(.NLINES(2)) u_lines (
        .clk (clk),
        .lvl ({dcd_lvl, cts_lvl}),
        .chg (line_chg)
    );

    evt_router u_route (
        .mode     (cur_mode),
        .evt      (evt),
        .line_chg (line_chg),
        .set_vec  (set_vec)
    );

    clr_router u_clr (
        .req     (creq),
        .clr_vec (clr_vec)
    );

    // Latched bits: a set beats a clear; bit 6 follows the idle level.
    always_comb begin
        nxt = ((stat & ~clr_vec) | set_vec) & vmask;
        nxt[B_TXIDLE] = tx_idle & ~clr_vec[B_TXIDLE];
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end

    assign reg_rdata = reg_sel ? (stat & vmask) : '0;
    assign irq       = |(stat & vmask & irq_mask);

    // ---------------- assertions ----------------
    assert_w1c_cts_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr && reg_wdata[B_CTS] && !line_chg[0]) |=> !stat[B_CTS]);

    assert_sticky_cts_R2: assert property (@(posedge clk) disable iff (rst)
        (stat[B_CTS] && !(host_wr && reg_wdata[B_CTS]) && !rx_rst_cmd
         && !chan_rst_cmd && !stop_mode) |=> stat[B_CTS]);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        set_vec[B_UNDR] |=> stat[B_UNDR]);

    assert_txbuf_idle_R7: assert property (@(posedge clk) disable iff (rst)
        txbuf_wr |=> !stat[B_TXIDLE]);

    assert_txrst_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_rst_cmd && !set_vec[B_UNDR] && !set_vec[B_DCD])
        |=> (!stat[B_UNDR] && !stat[B_TXIDLE] && !stat[B_DCD]));

    assert_rxrst_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_rst_cmd && (set_vec & RXRST_MASK) == '0) |=> ((stat & RXRST_MASK) == '0));

    assert_chan_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ((chan_rst_cmd || stop_mode) && set_vec == '0) |=> (stat == '0));

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat != '0));
endmodule

// File: tb/sim_chan_evt_status.sv
module sim_chan_evt_status;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic reg_sel = 1'b1, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00, irq_mask = 8'hFF;
    logic [7:0] reg_rdata;
    logic irq;
    logic tx_rst_cmd = 0, rx_rst_cmd = 0, txbuf_wr = 0, chan_rst_cmd = 0, stop_mode = 0;
    logic tx_idle = 0, cts_lvl = 0, dcd_lvl = 0;
    logic ev_underrun = 0, ev_brk_start = 0, ev_brk_end = 0, ev_clk_miss = 0;
    logic ev_syn_hit = 0, ev_flag = 0, ev_abort = 0, ev_idle_start = 0;

    int checks = 0, failures = 0;
    bit chk_on = 0, done = 0;
    string phase = "R1 reset";

    always #4 clk = ~clk;

    chan_evt_status u0 (.*);

    // ---------- behavioural reference ----------
    logic [7:0] m = 8'h00;
    logic pc = 0, pd = 0;

    function automatic logic [7:0] allowed(input logic [1:0] md);
        case (md)
            2'd0: return 8'h5E;
            2'd1: return 8'hDE;
            2'd2: return 8'hDF;
            default: return 8'h58;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] s, c, k;
        logic idle_bit;
        k = allowed(mode);
        s = 8'h00;
        if (cts_lvl != pc) s[4] = 1;
        if (dcd_lvl != pd) s[3] = 1;
        if (mode == 2'd0) begin s[2] = ev_brk_start; s[1] = ev_brk_end; end
        if (mode == 2'd1) begin s[7] = ev_underrun; s[2] = ev_clk_miss; s[1] = ev_syn_hit; end
        if (mode == 2'd2) begin
            s[7] = ev_underrun; s[2] = ev_abort; s[1] = ev_idle_start; s[0] = ev_flag;
        end
        c = 8'h00;
        if (reg_sel && reg_wr) c = c | (reg_wdata & 8'h9F);
        if (tx_rst_cmd) c = c | 8'h88;
        if (rx_rst_cmd) c = c | 8'h17;
        if (chan_rst_cmd || stop_mode) c = 8'hFF;
        idle_bit = tx_idle && !txbuf_wr && !tx_rst_cmd && !chan_rst_cmd && !stop_mode;
        pc = cts_lvl;
        pd = dcd_lvl;
        if (rst) m = 8'h00;
        else begin
            m = (((m & ~c) | s) & k) & 8'hBF;
            m[6] = idle_bit;
        end
    end

    always @(negedge clk) begin
        logic [7:0] er;
        logic ei;
        if (chk_on) begin
            er = reg_sel ? (m & allowed(mode)) : 8'h00;
            ei = |(m & allowed(mode) & irq_mask);
            checks++;
            if (reg_rdata !== er || irq !== ei) begin
                failures++;
                $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                         phase, reg_rdata, irq, er, ei);
            end
        end
    end

    task automatic nxt();
        @(negedge clk); #1;
        reg_wr = 0; tx_rst_cmd = 0; rx_rst_cmd = 0; txbuf_wr = 0; chan_rst_cmd = 0;
        ev_underrun = 0; ev_brk_start = 0; ev_brk_end = 0; ev_clk_miss = 0;
        ev_syn_hit = 0; ev_flag = 0; ev_abort = 0; ev_idle_start = 0;
    endtask

    task automatic all_events();
        ev_underrun = 1; ev_brk_start = 1; ev_brk_end = 1; ev_clk_miss = 1;
        ev_syn_hit = 1; ev_flag = 1; ev_abort = 1; ev_idle_start = 1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

    initial begin
        @(posedge clk); chk_on = 1;
        nxt(); nxt();
        phase = "R1 reset"; rst = 0; nxt();
        // R2 asynchronous events, R9 ignored ones
        phase = "R2 async break start"; ev_brk_start = 1; nxt(); nxt();
        phase = "R2 async break end";   ev_brk_end = 1;   nxt(); nxt();
        phase = "R9 async ignores sync events";
        ev_underrun = 1; ev_clk_miss = 1; ev_flag = 1; ev_syn_hit = 1; nxt(); nxt();
        // R8 modem lines, both edges
        phase = "R8 cts rise"; cts_lvl = 1; nxt(); nxt();
        phase = "R3 w1c cts"; reg_wr = 1; reg_wdata = 8'h10; nxt(); nxt();
        phase = "R8 cts fall"; cts_lvl = 0; nxt(); nxt();
        phase = "R8 dcd rise"; dcd_lvl = 1; nxt(); nxt();
        phase = "R8 dcd fall"; reg_wr = 1; reg_wdata = 8'h08; nxt(); dcd_lvl = 0; nxt(); nxt();
        phase = "R3 write zero keeps"; reg_wr = 1; reg_wdata = 8'h00; nxt(); nxt();
        phase = "R3 write ones"; reg_wr = 1; reg_wdata = 8'hFF; nxt(); nxt();
        phase = "R3 no read unselected"; ev_brk_start = 1; nxt(); reg_sel = 0; nxt(); nxt();
        phase = "R3 write unselected ignored"; reg_wr = 1; reg_wdata = 8'hFF; nxt(); reg_sel = 1; nxt();
        // R7 transmitter idle
        phase = "R7 idle level"; tx_idle = 1; nxt(); nxt();
        phase = "R7 buffer write"; reg_wr = 1; reg_wdata = 8'h40; txbuf_wr = 1; nxt(); nxt();
        // byte mode
        phase = "R2 byte mode"; mode = 2'd1; nxt();
        ev_underrun = 1; ev_clk_miss = 1; ev_syn_hit = 1; nxt(); nxt();
        phase = "R9 byte ignores"; reg_wr = 1; reg_wdata = 8'hFF; nxt();
        ev_brk_start = 1; ev_brk_end = 1; ev_flag = 1; ev_abort = 1; ev_idle_start = 1; nxt(); nxt();
        // bit mode
        phase = "R2 bit mode"; mode = 2'd2; nxt(); all_events(); nxt(); nxt();
        phase = "R4 tx reset"; cts_lvl = 1; nxt(); dcd_lvl = 1; nxt();
        tx_rst_cmd = 1; nxt(); nxt();
        phase = "R5 rx reset"; all_events(); nxt(); rx_rst_cmd = 1; nxt(); nxt();
        phase = "R10 set beats host clear"; ev_flag = 1; reg_wr = 1; reg_wdata = 8'hFF; nxt(); nxt();
        phase = "R10 set beats tx reset"; ev_underrun = 1; tx_rst_cmd = 1; nxt(); nxt();
        phase = "R10 set beats channel reset"; ev_abort = 1; chan_rst_cmd = 1; nxt(); nxt();
        phase = "R6 channel reset"; all_events(); nxt(); chan_rst_cmd = 1; nxt(); nxt();
        phase = "R6 stop mode"; all_events(); nxt(); stop_mode = 1; nxt(); nxt(); stop_mode = 0; nxt();
        phase = "R9 mode switch hides bits"; all_events(); nxt(); mode = 2'd0; nxt(); mode = 2'd3; nxt(); nxt();
        phase = "R11 mask patterns"; mode = 2'd2; all_events(); nxt();
        for (int i = 0; i < 8; i++) begin irq_mask = 8'h01 << i; nxt(); end
        irq_mask = 8'h00; nxt(); irq_mask = 8'h20; nxt();
        // random stream
        phase = "R2 R10 R11 random stream";
        for (int i = 0; i < 3000; i++) begin
            nxt();
            ev_underrun = ($urandom % 5) == 0; ev_brk_start = ($urandom % 5) == 0;
            ev_brk_end = ($urandom % 5) == 0;  ev_clk_miss = ($urandom % 5) == 0;
            ev_syn_hit = ($urandom % 5) == 0;  ev_flag = ($urandom % 5) == 0;
            ev_abort = ($urandom % 5) == 0;    ev_idle_start = ($urandom % 5) == 0;
            reg_wr = ($urandom % 4) == 0; reg_wdata = 8'($urandom);
            reg_sel = ($urandom % 8) != 0;
            tx_rst_cmd = ($urandom % 16) == 0; rx_rst_cmd = ($urandom % 16) == 0;
            txbuf_wr = ($urandom % 8) == 0; chan_rst_cmd = ($urandom % 40) == 0;
            stop_mode = ($urandom % 60) == 0;
            if (($urandom % 4) == 0) tx_idle = ~tx_idle;
            if (($urandom % 6) == 0) cts_lvl = ~cts_lvl;
            if (($urandom % 6) == 0) dcd_lvl = ~dcd_lvl;
            if (($urandom % 50) == 0) mode = 2'($urandom);
            if (($urandom % 30) == 0) irq_mask = 8'($urandom);
        end
        nxt(); stop_mode = 0; nxt(); nxt();
        done = 1;
        summary();
    end
endmodule